// File: doc/BRIEF.md
# Execute Packet Dispatcher

This block sits between instruction fetch and the functional units of a wide-issue core. It takes in one fetch packet at a time, holding eight instruction slots. Each slot carries an instruction word, a functional-unit select and a parallel bit. Runs of slots joined by set parallel bits form an execute packet. The block sends one execute packet per cycle to the functional-unit lanes, and each instruction goes out on the lane its unit field names. A fetch packet whose bits split it into several execute packets takes several cycles. During those cycles the fetch side is held off.

The controller has two states. `ST_IDLE` waits for a fetch packet. `ST_SPLIT` walks a cursor through the held packet and issues one group per cycle. Its transitions are:
- idle-to-split when a packet is accepted;
- split-to-split while groups remain, or when the final group issues and a new packet is accepted in that same cycle;
- split-to-idle when the final group issues and no new packet arrives.

If two instructions in one group name the same unit, the lower-numbered slot issues and a conflict flag is raised for that cycle.

Top module: `epd_dispatch`

## Requirements
- R1: After reset `fp_ready` is 1, every bit of `iss_valid` is 0 and `iss_conflict` is 0.
- R2: A set parallel bit on slot i (bit i of `fp_par`, i below 7) places slot i+1 in the same execute packet as slot i. A clear bit ends the execute packet at slot i.
- R3: The parallel bit of slot 7 is ignored and the packet always ends there. A fetch packet therefore issues as 1 plus the number of clear bits among `fp_par[6:0]` execute packets, and the next fetch packet always starts a new one.
- R4: A fetch packet with `fp_par[6:0]` all set issues all eight instructions in one cycle.
- R5: A fetch packet with `fp_par[6:0]` all clear issues over eight consecutive cycles, one instruction per cycle in slot order.
- R6: An issued instruction from slot i appears on lane u, where u = `fp_unit[3i+2:3i]`. It shows as `iss_valid[u]`=1 and `iss_insn[32u+31:32u]` equal to `fp_insn[32i+31:32i]`.
- R7: When two or more slots in one execute packet select the same unit, only the lowest-numbered of them issues on that lane, and `iss_conflict` is 1 in that issue cycle only.
- R8: `fp_ready` is 0 while execute packets other than the final one of the held packet remain. Inputs presented while `fp_ready` is 0 do not disturb the groups being issued.
- R9: The first execute packet appears on the outputs in the cycle after the accepting clock edge. Further groups follow on consecutive cycles. A packet accepted in the cycle of the previous packet's final group issues its first group in the very next cycle.
- R10: Lanes that receive no instruction in a cycle show `iss_valid`=0. In a cycle with no group, all lanes are 0 and `iss_conflict` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_valid | input | 1 | Fetch packet offered |
| fp_ready | output | 1 | Fetch packet can be taken this cycle |
| fp_insn | input | 256 | Eight 32-bit instruction words, slot i at bits 32i+31:32i |
| fp_unit | input | 24 | Eight 3-bit unit selects, slot i at bits 3i+2:3i |
| fp_par | input | 8 | Parallel bit per slot |
| iss_valid | output | 8 | Lane u holds an instruction this cycle |
| iss_insn | output | 256 | Instruction word per lane, lane u at bits 32u+31:32u |
| iss_conflict | output | 1 | Two slots of the current group selected one unit |

## Verification
A packet is accepted at the clock edge where `fp_valid` and `fp_ready` are both high. Its first group is registered onto the lanes at the next edge, and each later group follows one edge after the one before. `fp_ready` is combinational, so it is valid in the same cycle as the group it refers to. The bench drives inputs and samples outputs at the falling edge. It checks `fp_ready` before each issuing edge and the lane contents right after it. It sweeps all 256 parallel-bit patterns against three unit maps, some of which collide. It also runs a back-to-back transfer with the next packet held on the inputs throughout a split.

// File: rtl/epd_pkg.sv
package epd_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SPLIT = 1'b1
    } epd_state_e;
endpackage

// File: rtl/epd_group_finder.sv
// Finds the execute packet that starts at the cursor: chain through set
// parallel bits, always stopping at the last slot of the fetch packet.
module epd_group_finder #(
    parameter int SLOTS = 8,
    parameter int IDX_W = 3
) (
    input  logic [SLOTS-1:0] par,
    input  logic [IDX_W-1:0] cursor,
    output logic [SLOTS-1:0] grp_mask,
    output logic             grp_last,
    output logic [IDX_W-1:0] next_cursor
);
    logic             running;
    logic [IDX_W-1:0] end_idx;

    always_comb begin
        running  = 1'b1;
        grp_mask = '0;
        end_idx  = IDX_W'(SLOTS - 1);
        for (int i = 0; i < SLOTS; i++) begin
            if (i >= int'(cursor) && running) begin
                grp_mask[i] = 1'b1;
                if (i == SLOTS - 1 || !par[i]) begin
                    running = 1'b0;
                    end_idx = IDX_W'(i);
                end
            end
        end
    end

    assign grp_last    = (end_idx == IDX_W'(SLOTS - 1));
    assign next_cursor = end_idx + IDX_W'(1);
endmodule

// File: rtl/epd_lane_router.sv
// Steers each slot of the current group to the lane its unit field names;
// the lowest slot wins a lane, any further claimant raises the conflict.
module epd_lane_router #(
    parameter int SLOTS  = 8,
    parameter int UNITS  = 8,
    parameter int UNIT_W = 3,
    parameter int INSN_W = 32
) (
    input  logic [SLOTS-1:0]        grp_mask,
    input  logic [SLOTS*UNIT_W-1:0] units,
    input  logic [SLOTS*INSN_W-1:0] insns,
    output logic [UNITS-1:0]        lane_valid,
    output logic [UNITS*INSN_W-1:0] lane_insn,
    output logic                    lane_conflict
);
    logic [UNITS-1:0] lane_dup;

    for (genvar u = 0; u < UNITS; u++) begin : g_lane
        always_comb begin
            lane_valid[u]                 = 1'b0;
            lane_dup[u]                   = 1'b0;
            lane_insn[u*INSN_W +: INSN_W] = '0;
            for (int i = 0; i < SLOTS; i++) begin
                if (grp_mask[i] && units[i*UNIT_W +: UNIT_W] == UNIT_W'(u)) begin
                    if (!lane_valid[u]) begin
                        lane_valid[u]                 = 1'b1;
                        lane_insn[u*INSN_W +: INSN_W] = insns[i*INSN_W +: INSN_W];
                    end else begin
                        lane_dup[u] = 1'b1;
                    end
                end
            end
        end
    end

    assign lane_conflict = |lane_dup;
endmodule

// File: rtl/epd_dispatch.sv
module epd_dispatch
    import epd_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int UNITS  = 8,
    parameter int UNIT_W = $clog2(UNITS),
    parameter int INSN_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fp_valid,
    output logic                    fp_ready,
    input  logic [SLOTS*INSN_W-1:0] fp_insn,
    input  logic [SLOTS*UNIT_W-1:0] fp_unit,
    input  logic [SLOTS-1:0]        fp_par,
    output logic [UNITS-1:0]        iss_valid,
    output logic [UNITS*INSN_W-1:0] iss_insn,
    output logic                    iss_conflict
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    epd_state_e              state_q, state_d;
    logic [IDX_W-1:0]        cursor_q;
    logic [SLOTS-1:0]        held_par;
    logic [SLOTS*UNIT_W-1:0] held_unit;
    logic [SLOTS*INSN_W-1:0] held_insn;

    logic [SLOTS-1:0]        grp_mask;
    logic                    grp_last;
    logic [IDX_W-1:0]        next_cursor;
    logic [UNITS-1:0]        lane_valid;
    logic [UNITS*INSN_W-1:0] lane_insn;
    logic                    lane_conflict;
    logic                    accept;

    epd_group_finder #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_finder (
        .par        (held_par),
        .cursor     (cursor_q),
        .grp_mask   (grp_mask),
        .grp_last   (grp_last),
        .next_cursor(next_cursor)
    );

    epd_lane_router #(
        .SLOTS(SLOTS), .UNITS(UNITS), .UNIT_W(UNIT_W), .INSN_W(INSN_W)
    ) u_router (
        .grp_mask     (grp_mask),
        .units        (held_unit),
        .insns        (held_insn),
        .lane_valid   (lane_valid),
        .lane_insn    (lane_insn),
        .lane_conflict(lane_conflict)
    );

    // Fetch may hand over the next packet in the cycle the final group leaves.
    assign fp_ready = (state_q == ST_IDLE) || (state_q == ST_SPLIT && grp_last);
    assign accept   = fp_valid && fp_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_SPLIT : ST_IDLE;
            ST_SPLIT: begin
                if (grp_last) state_d = accept ? ST_SPLIT : ST_IDLE;
                else          state_d = ST_SPLIT;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register, cursor and held fetch packet.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cursor_q  <= '0;
            held_par  <= '0;
            held_unit <= '0;
            held_insn <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                held_par  <= fp_par;
                held_unit <= fp_unit;
                held_insn <= fp_insn;
                cursor_q  <= '0;
            end else if (state_q == ST_SPLIT) begin
                cursor_q <= next_cursor;
            end
        end
    end

    // Registered lane outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss_valid    <= '0;
            iss_insn     <= '0;
            iss_conflict <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SPLIT: begin
                    iss_valid    <= lane_valid;
                    iss_insn     <= lane_insn;
                    iss_conflict <= lane_conflict;
                end
                default: begin
                    iss_valid    <= '0;
                    iss_insn     <= '0;
                    iss_conflict <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/epd_dispatch_checker.sv
module epd_dispatch_checker #(
    parameter int UNITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fp_valid,
    input logic             fp_ready,
    input logic [UNITS-1:0] iss_valid,
    input logic             iss_conflict
);
    // R1: outputs are quiet and fetch is open right after reset
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (iss_valid == '0 && !iss_conflict && fp_ready));

    // R7: a conflict is only flagged alongside an issued group
    assert_conflict_with_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_conflict |-> (iss_valid != '0));

    // R8: a held-off fetch side means a non-final group issues next
    assert_stall_issues_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_ready |=> (iss_valid != '0));

    // R9: the first group of an accepted packet reaches the lanes one cycle later
    assert_accept_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && fp_ready) |-> ##2 (iss_valid != '0));

    // R10: with nothing offered, lanes fall silent once the held packet is done
    assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_ready && !fp_valid) |-> ##2 (iss_valid == '0 && !iss_conflict));
endmodule

bind epd_dispatch epd_dispatch_checker #(.UNITS(UNITS)) u_epd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fp_valid    (fp_valid),
    .fp_ready    (fp_ready),
    .iss_valid   (iss_valid),
    .iss_conflict(iss_conflict)
);

// File: tb/test_epd_dispatch.sv
`timescale 1ns/1ps
module test_epd_dispatch;
    localparam int SLOTS  = 8;
    localparam int UNITS  = 8;
    localparam int UNIT_W = 3;
    localparam int INSN_W = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    fp_valid = 1'b0;
    logic                    fp_ready;
    logic [SLOTS*INSN_W-1:0] fp_insn = '0;
    logic [SLOTS*UNIT_W-1:0] fp_unit = '0;
    logic [SLOTS-1:0]        fp_par = '0;
    logic [UNITS-1:0]        iss_valid;
    logic [UNITS*INSN_W-1:0] iss_insn;
    logic                    iss_conflict;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    epd_dispatch #(.SLOTS(SLOTS), .UNITS(UNITS), .INSN_W(INSN_W)) i_epd_dispatch (
        .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_ready(fp_ready),
        .fp_insn(fp_insn), .fp_unit(fp_unit), .fp_par(fp_par),
        .iss_valid(iss_valid), .iss_insn(iss_insn), .iss_conflict(iss_conflict)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Build one fetch packet from a pattern number and a unit-map choice.
    task automatic make_pkt(input int p, input int s,
                            output logic [SLOTS-1:0] par,
                            output logic [SLOTS*UNIT_W-1:0] un,
                            output logic [SLOTS*INSN_W-1:0] ins);
        par = SLOTS'(p);
        for (int i = 0; i < SLOTS; i++) begin
            int u;
            case (s)
                0:       u = i;
                1:       u = (i * 5 + p) % 8;
                default: u = (i + p) % 4;
            endcase
            un[i*UNIT_W +: UNIT_W] = UNIT_W'(u);
            ins[i*INSN_W +: INSN_W] = 32'hC0DE0000 ^ INSN_W'(p * 256 + s * 16 + i);
        end
    endtask

    task automatic present(input logic [SLOTS-1:0] par, input logic [SLOTS*UNIT_W-1:0] un,
                           input logic [SLOTS*INSN_W-1:0] ins, input logic v);
        fp_par = par; fp_unit = un; fp_insn = ins; fp_valid = v;
    endtask

    // Called at the negedge after the accepting edge. Walks the expected groups,
    // optionally presenting a follow-on packet for the whole split.
    task automatic drain(input logic [SLOTS-1:0] par, input logic [SLOTS*UNIT_W-1:0] un,
                         input logic [SLOTS*INSN_W-1:0] ins, input string tag,
                         input logic nv, input logic [SLOTS-1:0] npar,
                         input logic [SLOTS*UNIT_W-1:0] nun,
                         input logic [SLOTS*INSN_W-1:0] nins);
        int cur = 0;
        int groups = 0;
        int zeros = 0;
        present(npar, nun, nins, nv);
        for (int i = 0; i < SLOTS - 1; i++) if (!par[i]) zeros++;
        forever begin
            logic [SLOTS-1:0] mask = '0;
            int endi = SLOTS - 1;
            bit last;
            bit conf = 1'b0;
            for (int i = cur; i < SLOTS; i++) begin
                mask[i] = 1'b1;
                if (i == SLOTS - 1 || !par[i]) begin endi = i; break; end
            end
            last = (endi == SLOTS - 1);
            chk(fp_ready == last, "R8", {tag, " fp_ready before issue"}, fp_ready, last);
            @(posedge clk);
            @(negedge clk);
            groups++;
            for (int u = 0; u < UNITS; u++) begin
                bit ev = 1'b0;
                logic [INSN_W-1:0] ei = '0;
                for (int i = 0; i < SLOTS; i++) begin
                    if (mask[i] && int'(un[i*UNIT_W +: UNIT_W]) == u) begin
                        if (!ev) begin ev = 1'b1; ei = ins[i*INSN_W +: INSN_W]; end
                        else conf = 1'b1;
                    end
                end
                chk(iss_valid[u] == ev, "R2/R10", {tag, " lane valid"}, iss_valid[u], ev);
                if (ev)
                    chk(iss_insn[u*INSN_W +: INSN_W] == ei, "R6", {tag, " lane word"},
                        iss_insn[u*INSN_W +: INSN_W], ei);
            end
            chk(iss_conflict == conf, "R7", {tag, " conflict flag"}, iss_conflict, conf);
            if (last) break;
            cur = endi + 1;
        end
        chk(groups == 1 + zeros, "R3", {tag, " group count"}, groups, 1 + zeros);
        if (par[SLOTS-2:0] == '1)
            chk(groups == 1, "R4", {tag, " fully parallel"}, groups, 1);
        if (par[SLOTS-2:0] == '0)
            chk(groups == 8, "R5", {tag, " fully serial"}, groups, 8);
    endtask

    task automatic send(input logic [SLOTS-1:0] par, input logic [SLOTS*UNIT_W-1:0] un,
                        input logic [SLOTS*INSN_W-1:0] ins);
        while (!fp_ready) @(negedge clk);
        present(par, un, ins, 1'b1);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R9 run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [SLOTS-1:0] pa, pb;
        logic [SLOTS*UNIT_W-1:0] ua, ub;
        logic [SLOTS*INSN_W-1:0] ia, ib;

        repeat (3) @(negedge clk);
        chk(fp_ready == 1'b1, "R1", "ready in reset", fp_ready, 1);
        chk(iss_valid == '0, "R1", "lanes in reset", iss_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(iss_valid == '0 && !iss_conflict, "R1", "quiet after reset", iss_valid, 0);

        // Sweep every parallel-bit pattern against three unit maps.
        for (int p = 0; p < 256; p++) begin
            for (int s = 0; s < 3; s++) begin
                make_pkt(p, s, pa, ua, ia);
                send(pa, ua, ia);
                drain(pa, ua, ia, "sweep", 1'b0, '0, '0, '0);
                @(posedge clk);
                @(negedge clk);
                chk(iss_valid == '0 && !iss_conflict, "R10", "idle after packet",
                    iss_valid, 0);
            end
        end

        // Back-to-back: next packet held on the inputs throughout a split.
        make_pkt(8'h05, 0, pa, ua, ia);
        make_pkt(8'h7F, 1, pb, ub, ib);
        send(pa, ua, ia);
        drain(pa, ua, ia, "R9 first", 1'b1, pb, ub, ib);
        drain(pb, ub, ib, "R9 follow-on", 1'b0, '0, '0, '0);

        // All slots on one unit: lowest slot wins, conflict raised.
        make_pkt(8'hFF, 0, pa, ua, ia);
        ua = '0;
        send(pa, ua, ia);
        drain(pa, ua, ia, "R7 collide", 1'b0, '0, '0, '0);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule